// File: doc/BRIEF.md
# Retract and Brake Shutdown Sequencer

This block supervises power-down of a disk drive's head actuator (voice coil motor, VCM) and spindle motor. It watches three hardware shutdown sources: a supply-undervoltage flag, an overtemperature flag and an active-low forced-retract pin. It also watches a small control word made of a run-enable bit, an idle bit and a spindle-brake bit. That word is captured only on a one-cycle commit strobe, which marks the rising edge of the serial chip select.

When a shutdown source fires, or when the run-enable bit is committed as 0 while the motors run, the block enters a timed retract. For a programmable number of cycles, both motor drives are off and only the retract path is on. When the count expires, retract stops and the low-side brake is applied to both motors. The block then stays parked until software commits run-enable as 1 again with no shutdown source present and the power-on timer finished.

After reset the block is parked (sleep mode). An active-low fault flag reports undervoltage, overtemperature and the power-on settling interval.

Top module: `retract_sequencer`

## Requirements
- R1: After reset the block is parked: spindle and VCM drives off, retract off, and both brake outputs (spindle and VCM) at 1.
- R2: `fault_n_o` is 0 during the first POR_CYCLES cycles after reset is released, and in any cycle where `uv_i` or `ot_i` is 1. Otherwise it is 1.
- R3: The block leaves the parked state for normal running one cycle after a commit with `run_en_i`=1, provided no shutdown source is active. A commit made while the power-on timer is still running is discarded.
- R4: While running, the idle bit (1) turns the VCM drive off and applies the VCM brake with the spindle still driven. The spindle-brake bit (1) turns the spindle drive off and applies the spindle brake with the VCM still driven. Both bits change only on a commit.
- R5: While running, `uv_i`=1, `ot_i`=1 or `force_n_i`=0 makes `retract_o` rise on the next cycle.
- R6: While running, a commit with `run_en_i`=0 makes `retract_o` rise on the next cycle.
- R7: `retract_o` stays 1 for exactly ONESHOT_CYCLES consecutive cycles. During that time all drives and brakes are 0, and further triggers neither extend nor restart the count.
- R8: In the cycle after retract ends, both brake outputs are 1 and both drives are 0 until a new run entry.
- R9: `spin_restart_o` is a one-cycle pulse in the first cycle of every interval in which `spin_en_o` is 1. This restarts commutation from its initial state.
- R10: Any shutdown source clears the stored run-enable bit, and commits made while a source is active are discarded. Running resumes only after a fresh commit with `run_en_i`=1 once all sources are gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| uv_i | input | 1 | Supply undervoltage flag |
| ot_i | input | 1 | Overtemperature flag |
| force_n_i | input | 1 | Forced retract, active low |
| commit_i | input | 1 | One-cycle strobe that captures the control bits |
| run_en_i | input | 1 | Control bit: 1 = normal operation, 0 = sleep |
| idle_i | input | 1 | Control bit: 1 = VCM off and braked |
| spin_brake_i | input | 1 | Control bit: 1 = spindle off and braked |
| spin_en_o | output | 1 | Spindle drive enable |
| vcm_en_o | output | 1 | VCM drive enable |
| retract_o | output | 1 | Head retract path on |
| spin_brake_o | output | 1 | Spindle low-side brake |
| vcm_brake_o | output | 1 | VCM low-side brake |
| spin_restart_o | output | 1 | Commutation restart pulse |
| fault_n_o | output | 1 | Fault flag, active low |

## Verification
The assertions assume that every input is synchronous to `clk` and that `commit_i` is a single-cycle strobe whose data bits are valid in the same cycle. The stimulus drives every input on the falling edge and pulses commit for one cycle at a time, so these assumptions hold. It also overlaps shutdown sources with one another, with commits and with an active retract, because the priority rules live in those overlaps.

// File: rtl/retract_sequencer.sv
module retract_sequencer #(
  parameter int ONESHOT_CYCLES = 12_500_000,
  parameter int POR_CYCLES     = 62_500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_i,
  input  logic ot_i,
  input  logic force_n_i,
  input  logic commit_i,
  input  logic run_en_i,
  input  logic idle_i,
  input  logic spin_brake_i,
  output logic spin_en_o,
  output logic vcm_en_o,
  output logic retract_o,
  output logic spin_brake_o,
  output logic vcm_brake_o,
  output logic spin_restart_o,
  output logic fault_n_o
);
  localparam int OW = $clog2(ONESHOT_CYCLES + 1);
  localparam int PW = $clog2(POR_CYCLES + 1);
  localparam logic [OW-1:0] OS_LAST = OW'(ONESHOT_CYCLES - 1);
  localparam logic [PW-1:0] POR_END = PW'(POR_CYCLES);

  typedef enum logic [1:0] {PARK, RUN, RET} st_t;

  st_t            st;
  logic [OW-1:0]  os_cnt;
  logic [PW-1:0]  por_cnt;
  logic           run_q, idle_q, sbrk_q, spin_q;

  wire por_busy = por_cnt != POR_END;
  wire hw_trig  = uv_i | ot_i | ~force_n_i;
  wire running  = st == RUN;
  wire parked   = st == PARK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) por_cnt <= '0;
    else if (por_busy) por_cnt <= por_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idle_q <= 1'b0;
      sbrk_q <= 1'b0;
    end else begin
      if (hw_trig || por_busy) run_q <= 1'b0;
      else if (commit_i)       run_q <= run_en_i;
      if (commit_i) begin
        idle_q <= idle_i;
        sbrk_q <= spin_brake_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PARK;
      os_cnt <= '0;
    end else begin
      case (st)
        PARK: if (run_q && !hw_trig) st <= RUN;
        RUN: if (hw_trig || (commit_i && !run_en_i)) begin
          st     <= RET;
          os_cnt <= '0;
        end
        RET: begin
          os_cnt <= os_cnt + 1'b1;
          if (os_cnt == OS_LAST) st <= PARK;
        end
        default: st <= PARK;
      endcase
    end
  end

  assign spin_en_o    = running & ~sbrk_q;
  assign vcm_en_o     = running & ~idle_q;
  assign retract_o    = st == RET;
  assign spin_brake_o = parked | (running & sbrk_q);
  assign vcm_brake_o  = parked | (running & idle_q);
  assign fault_n_o    = ~(uv_i | ot_i | por_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spin_q <= 1'b0;
    else        spin_q <= spin_en_o;
  end
  assign spin_restart_o = spin_en_o & ~spin_q;

  // R7
  retract_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retract_o |-> !(spin_en_o || vcm_en_o || spin_brake_o || vcm_brake_o));
  // R8
  brake_after_retract_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(retract_o) |-> (spin_brake_o && vcm_brake_o && !spin_en_o && !vcm_en_o));
  // R5
  trig_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && hw_trig) |=> retract_o);
  // R9
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spin_restart_o |=> !spin_restart_o);
  // R2
  uv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_i || ot_i) |-> !fault_n_o);
endmodule

// File: tb/retract_sequencer_tb.sv
module retract_sequencer_tb;
  localparam int OS  = 30;
  localparam int POR = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic uv = 0, ot = 0, force_n = 1, commit = 0, run_en = 0, idle = 0, sbrk = 0;
  logic spin_en, vcm_en, retract, spin_brk, vcm_brk, restart, fault_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  retract_sequencer #(.ONESHOT_CYCLES(OS), .POR_CYCLES(POR)) u_dut (
    .clk(clk), .rst_n(rst_n), .uv_i(uv), .ot_i(ot), .force_n_i(force_n),
    .commit_i(commit), .run_en_i(run_en), .idle_i(idle), .spin_brake_i(sbrk),
    .spin_en_o(spin_en), .vcm_en_o(vcm_en), .retract_o(retract),
    .spin_brake_o(spin_brk), .vcm_brake_o(vcm_brk), .spin_restart_o(restart),
    .fault_n_o(fault_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 parked, 1 running, 2 retracting
  int  m_mode = 0, m_left = 0, m_age = 0;
  bit  m_armed = 0, m_idle = 0, m_sbrk = 0, m_spin_was = 0;

  function automatic bit e_spin();   return m_mode == 1 && !m_sbrk; endfunction
  function automatic bit e_vcm();    return m_mode == 1 && !m_idle; endfunction
  function automatic bit e_ret();    return m_mode == 2; endfunction
  function automatic bit e_sbrk();   return m_mode == 0 || (m_mode == 1 && m_sbrk); endfunction
  function automatic bit e_vbrk();   return m_mode == 0 || (m_mode == 1 && m_idle); endfunction
  function automatic bit e_fault_n(); return !(uv || ot || m_age < POR); endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_age = 0; m_armed = 0; m_idle = 0; m_sbrk = 0; m_spin_was = 0;
    end else begin
      bit src, spin_now;
      src = uv || ot || !force_n;
      spin_now = e_spin();
      if (m_mode == 0) begin
        if (m_armed && !src) m_mode = 1;
      end else if (m_mode == 1) begin
        if (src || (commit && !run_en)) begin m_mode = 2; m_left = OS; end
      end else begin
        m_left--;
        if (m_left == 0) m_mode = 0;
      end
      if (src || m_age < POR) m_armed = 0;
      else if (commit) m_armed = run_en;
      if (commit) begin m_idle = idle; m_sbrk = sbrk; end
      if (m_age < POR) m_age++;
      m_spin_was = spin_now;
    end
  end

  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      chk(spin_en == e_spin(), "R4 spin_en", spin_en, e_spin());
      chk(vcm_en == e_vcm(), "R4 vcm_en", vcm_en, e_vcm());
      chk(retract == e_ret(), "R7 retract", retract, e_ret());
      chk(spin_brk == e_sbrk(), "R8 spin_brake", spin_brk, e_sbrk());
      chk(vcm_brk == e_vbrk(), "R8 vcm_brake", vcm_brk, e_vbrk());
      chk(fault_n == e_fault_n(), "R2 fault_n", fault_n, e_fault_n());
      chk(restart == (e_spin() && !m_spin_was), "R9 restart", restart, e_spin() && !m_spin_was);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit en, input bit id, input bit sb);
    @(negedge clk);
    commit = 1; run_en = en; idle = id; sbrk = sb;
    @(negedge clk);
    commit = 0;
  endtask

  task automatic measure_retract(input string req);
    int n = 0;
    #1;
    while (!retract && n < 5) begin @(negedge clk); #1; n++; end
    chk(n == 1, {req, " retract start delay"}, n, 1);
    n = 0;
    while (retract && n < OS + 10) begin @(negedge clk); #1; n++; end
    chk(n == OS, "R7 retract length", n, OS);
    chk(spin_brk && vcm_brk && !spin_en && !vcm_en, "R8 parked after retract", spin_brk, 1);
  endtask

  initial begin
    cyc(3);
    #1;
    chk(!spin_en && !vcm_en && !retract && spin_brk && vcm_brk, "R1 reset parked", spin_brk, 1);
    rst_n = 1;
    cyc(1); #1;
    chk(fault_n == 0, "R2 por fault", fault_n, 0);
    wr(1, 0, 0);
    cyc(POR + 2); #1;
    chk(!spin_en && spin_brk, "R3 commit during por discarded", spin_en, 0);
    chk(fault_n == 1, "R2 por over", fault_n, 1);
    wr(1, 0, 0); #1;
    chk(!spin_en, "R3 one-cycle latency", spin_en, 0);
    @(negedge clk); #1;
    chk(spin_en && vcm_en, "R3 run entry", spin_en, 1);
    chk(restart == 1, "R9 restart on entry", restart, 1);
    wr(1, 1, 0); #1;
    chk(spin_en && !vcm_en && vcm_brk && !spin_brk, "R4 idle", vcm_en, 0);
    wr(1, 0, 1); #1;
    chk(!spin_en && vcm_en && spin_brk && !vcm_brk, "R4 spindle brake", spin_en, 0);
    @(negedge clk); idle = 1; sbrk = 0;
    cyc(2); #1;
    chk(!spin_en, "R4 bits need commit", spin_en, 0);
    wr(1, 0, 0); #1;
    chk(restart == 1, "R9 restart after brake release", restart, 1);
    // undervoltage; triggers during retract do not extend it
    @(negedge clk); uv = 1;
    #1; chk(fault_n == 0, "R2 uv fault", fault_n, 0);
    fork
      measure_retract("R5 uv");
      begin cyc(5); force_n = 0; cyc(3); force_n = 1; wr(1, 0, 0); end
    join
    uv = 0;
    cyc(3); #1;
    chk(!spin_en && !vcm_en, "R10 stays parked after uv", spin_en, 0);
    wr(1, 0, 0); cyc(1); #1;
    chk(spin_en, "R10 fresh enable resumes", spin_en, 1);
    // sleep command
    @(negedge clk); commit = 1; run_en = 0;
    @(negedge clk); commit = 0; #1;
    chk(retract == 1, "R6 sleep retract", retract, 1);
    cyc(OS + 2);
    wr(1, 0, 0); cyc(2);
    @(negedge clk); ot = 1;
    measure_retract("R5 ot");
    ot = 0; wr(1, 0, 0); cyc(2);
    @(negedge clk); force_n = 0;
    measure_retract("R5 force");
    wr(1, 1, 1); cyc(2); #1;
    chk(!spin_en, "R10 commit while forced discarded", spin_en, 0);
    force_n = 1; cyc(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule